// File: doc/BRIEF.md
# Prioritized Interrupt Request Controller with Trigger Modes

This block gathers up to fifteen external interrupt requests, numbered 1 to 15. It turns them into a single 4-bit request level for a processor. Each source has its own 2-bit trigger mode:

- level-sensitive, active high
- level-sensitive, active low
- rising-edge sensitive
- falling-edge sensitive

Raw inputs are brought into the clock domain by a two-flop synchronizer. A detector then raises a set pulse according to the mode, and the pulse lands in a per-source pending register. Software sees that register through a sense register and clears bits by writing ones to a clear register. A mask register holds one disable bit per source.

The highest-numbered pending source whose mask bit is clear is the best candidate. A two-state level latch captures that candidate and drives the level output. The latch is `LV_IDLE` (nothing held, output 0) or `LV_HELD` (a nonzero level held). Its transitions are:

- `ENTER` (`LV_IDLE` to `LV_HELD`): taken when a candidate exists.
- `WAIT` (stay in `LV_IDLE`): taken while no candidate exists.
- `RAISE` (stay in `LV_HELD`, new level): taken when a strictly higher candidate appears.
- `KEEP` (stay in `LV_HELD`, same level): taken otherwise.
- `RELEASE` (`LV_HELD` to `LV_IDLE`): taken when software writes the level register with bit 4 set.

Software reads the held level back from the same register. The bus is word-addressed with separate read and write strobes. Read data is combinational while the read strobe is high and zero otherwise.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset the level output is 0 and the level register reads 0. The sense register reads 0, the mask register (word 4) reads 16'hFFFE, and both trigger registers (words 0 and 1) read 0.
- R2: Trigger code 00 (level, active high) works as follows. A high input sets its pending bit (sense register, word 2, bit = source number) on the third rising clock edge after the input changes, counting the edge that first samples it, and not before. Clearing the bit while the input stays high leaves it set. After the input drops, the bit stays set until it is cleared.
- R3: Trigger code 01 (level, active low) treats a low input as active and a high input as inactive.
- R4: Trigger code 10 (rising edge) sets the pending bit once per low-to-high transition. A held-high input does not set it again after a clear, and a high-to-low transition does not set it.
- R5: Trigger code 11 (falling edge) sets the pending bit on a high-to-low transition only.
- R6: Writing to the clear register (word 3) clears exactly the pending bits written as 1. Bits written as 0 are unchanged.
- R7: A mask bit of 1 (word 4, bit = source number) keeps a source out of the level output while its pending bit still latches. Clearing the mask bit of a pending source, while the latch is in `LV_IDLE`, presents that level one clock edge after the write edge.
- R8: The level taken on `ENTER` is the highest source number among pending, unmasked sources, or 0 when there is none.
- R9: While `LV_HELD`, a new lower-numbered candidate leaves the level unchanged (`KEEP`). A strictly higher one replaces it (`RAISE`).
- R10: Writing word 5 with bit 4 set performs `RELEASE`: the level reads 0 right after the write edge, and the best candidate is latched on the next edge. A write to word 5 with bit 4 clear has no effect. Word 5 reads the held level in bits 3:0.
- R11: Trigger fields are placed as follows. Word 0 holds source s in bits [2(s-8)+1 : 2(s-8)] for s from 8 to 15. Word 1 holds source s in bits [2s+1 : 2s] for s from 1 to 7. Word 1 bits 1:0 always read 0. The upper bit of a field selects edge, the lower bit selects low/falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register word index (0 to 5) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when bus_rd is low |
| irq_in | input | 15 | Raw requests; bit k-1 is source k |
| irl_out | output | 4 | Held interrupt level, 0 when idle |

## Verification
A raw input change reaches the sense register after three rising edges and the level output after four. A mask or clear-level write shows on the level output one edge after the write edge. A request-clear write shows at once in the sense read that follows.

The bench drives and reads on falling edges. The latency checks for R2 and R7 sample at exactly those edges: once before the change is due, where the old value is expected, and once after. The other checks wait several cycles so that only the settled value matters. The priority table clears the latch before each row, so that every row starts from `ENTER`.

// File: rtl/icu_pkg.sv
package icu_pkg;
    localparam int NUM_SRC     = 15;
    localparam int DATA_W      = NUM_SRC + 1;
    localparam int LVL_W       = $clog2(NUM_SRC + 1);
    localparam int SPLIT       = 8;
    localparam int ADDR_W      = 3;
    localparam int LVL_CLR_BIT = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_TRIG_HI = 3'd0,
        REG_TRIG_LO = 3'd1,
        REG_SENSE   = 3'd2,
        REG_CLEAR   = 3'd3,
        REG_MASK    = 3'd4,
        REG_LEVEL   = 3'd5
    } reg_idx_e;

    typedef enum logic [1:0] {
        TRG_LVL_HI    = 2'b00,
        TRG_LVL_LO    = 2'b01,
        TRG_EDGE_RISE = 2'b10,
        TRG_EDGE_FALL = 2'b11
    } trig_e;

    typedef enum logic {
        LV_IDLE = 1'b0,
        LV_HELD = 1'b1
    } lvl_state_e;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    logic [W-1:0] meta_q;
    logic [W-1:0] cur_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            cur_q  <= '0;
            prev_q <= '0;
        end else begin
            meta_q <= raw;
            cur_q  <= meta_q;
            prev_q <= cur_q;
        end
    end

    assign cur  = cur_q;
    assign prev = prev_q;
endmodule

// File: rtl/icu_detect.sv
module icu_detect
    import icu_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic [N:1]      cur,
    input  logic [N:1]      prev,
    input  logic [N:1][1:0] mode,
    output logic [N:1]      set
);
    for (genvar s = 1; s <= N; s++) begin : g_src
        logic hit;
        always_comb begin
            unique case (trig_e'(mode[s]))
                TRG_LVL_HI:    hit = cur[s];
                TRG_LVL_LO:    hit = ~cur[s];
                TRG_EDGE_RISE: hit = cur[s] & ~prev[s];
                TRG_EDGE_FALL: hit = ~cur[s] & prev[s];
            endcase
        end
        assign set[s] = hit;
    end
endmodule

// File: rtl/icu_pending.sv
module icu_pending #(
    parameter int N = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [N:1] set,
    input  logic [N:1] clr,
    output logic [N:1] pend
);
    logic [N:1] pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr) | set;
    end

    assign pend = pend_q;

    // R6
    clear_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr & ~set) != '0) |=> ((pend_q & $past(clr & ~set)) == '0));

    // R2
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((pend_q & $past(set)) == $past(set)));
endmodule

// File: rtl/icu_level.sv
module icu_level
    import icu_pkg::*;
#(
    parameter int N = NUM_SRC,
    parameter int W = LVL_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N:1]   req,
    input  logic         clr_lvl,
    output logic [W-1:0] level
);
    lvl_state_e   state_q, state_d;
    logic [W-1:0] level_q, level_d;
    logic [W-1:0] best;

    function automatic logic [W-1:0] top_src(input logic [N:1] r);
        logic [W-1:0] res;
        res = '0;
        for (int i = 1; i <= N; i++) begin
            if (r[i]) res = W'(i);
        end
        return res;
    endfunction

    assign best = top_src(req);

    always_comb begin
        state_d = state_q;
        level_d = level_q;
        unique case (state_q)
            LV_IDLE: begin
                if (best != '0) begin      // ENTER
                    state_d = LV_HELD;
                    level_d = best;
                end                        // WAIT otherwise
            end
            LV_HELD: begin
                if (clr_lvl) begin         // RELEASE
                    state_d = LV_IDLE;
                    level_d = '0;
                end else if (best > level_q) begin
                    level_d = best;        // RAISE
                end                        // KEEP otherwise
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LV_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= '0;
        else        level_q <= level_d;
    end

    assign level = level_q;

    // R8
    best_is_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (best != '0) |-> (({req, 1'b0} >> best) == {{N{1'b0}}, 1'b1}));

    // R8
    enter_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_IDLE && best != '0) |=> (level_q == $past(best)));

    // R9
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_HELD && !clr_lvl) |=> (level_q >= $past(level_q)));

    // R10
    held_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_HELD) |-> (level_q != '0));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import icu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NUM_SRC-1:0] irq_in,
    output logic [LVL_W-1:0]  irl_out
);
    logic [DATA_W-1:0]       trig_hi_q, trig_lo_q, mask_q;
    logic [NUM_SRC:1]        cur, prev, set, clr, pend, req;
    logic [NUM_SRC:1][1:0]   mode;
    logic [LVL_W-1:0]        level;
    logic                    clr_lvl;
    reg_idx_e                idx;

    assign idx = reg_idx_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trig_hi_q <= '0;
            trig_lo_q <= '0;
            mask_q    <= {{NUM_SRC{1'b1}}, 1'b0};
        end else if (bus_wr) begin
            unique case (idx)
                REG_TRIG_HI: trig_hi_q <= bus_wdata;
                REG_TRIG_LO: trig_lo_q <= bus_wdata & ~DATA_W'(3);
                REG_MASK:    mask_q    <= {bus_wdata[DATA_W-1:1], 1'b0};
                default: ;
            endcase
        end
    end

    for (genvar s = 1; s <= NUM_SRC; s++) begin : g_mode
        if (s >= SPLIT) begin : g_hi
            assign mode[s] = trig_hi_q[2*(s-SPLIT) +: 2];
        end else begin : g_lo
            assign mode[s] = trig_lo_q[2*s +: 2];
        end
    end

    assign clr     = (bus_wr && idx == REG_CLEAR) ? bus_wdata[NUM_SRC:1] : '0;
    assign clr_lvl = bus_wr && idx == REG_LEVEL && bus_wdata[LVL_CLR_BIT];
    assign req     = pend & ~mask_q[NUM_SRC:1];

    icu_sync #(.W(NUM_SRC)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (irq_in),
        .cur  (cur),
        .prev (prev)
    );

    icu_detect #(.N(NUM_SRC)) u_detect (
        .cur (cur),
        .prev(prev),
        .mode(mode),
        .set (set)
    );

    icu_pending #(.N(NUM_SRC)) u_pend (
        .clk  (clk),
        .rst_n(rst_n),
        .set  (set),
        .clr  (clr),
        .pend (pend)
    );

    icu_level #(.N(NUM_SRC), .W(LVL_W)) u_level (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (req),
        .clr_lvl(clr_lvl),
        .level  (level)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (idx)
                REG_TRIG_HI: bus_rdata = trig_hi_q;
                REG_TRIG_LO: bus_rdata = trig_lo_q;
                REG_SENSE:   bus_rdata = {pend, 1'b0};
                REG_MASK:    bus_rdata = mask_q;
                REG_LEVEL:   bus_rdata = DATA_W'(level);
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign irl_out = level;

    // R7
    masked_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req == '0 && level == '0) |=> (irl_out == '0));

    // R1
    mask_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && idx == REG_MASK) |-> (bus_rdata[0] == 1'b0));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] raw = '0;
    logic [3:0]  irl_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // rows: {raw requests, mask, expected level}
    localparam logic [47:0] VEC [0:7] = '{
        48'h0002_0000_0001,
        48'h8002_0000_000F,
        48'h8002_8000_0001,
        48'h0F00_0C00_0009,
        48'h00F0_00F0_0000,
        48'h7FFE_0000_000E,
        48'h1234_1000_0009,
        48'h4001_0000_000E
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_wr   (bus_wr),
        .bus_rd   (bus_rd),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .irq_in   (raw[15:1]),
        .irl_out  (irl_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        check("R1 irl", {12'h0, irl_out}, 16'h0);
        rd(3'd2, v); check("R1 sense", v, 16'h0);
        rd(3'd4, v); check("R1 mask", v, 16'hFFFE);
        rd(3'd0, v); check("R1 trig_hi", v, 16'h0);
        rd(3'd1, v); check("R1 trig_lo", v, 16'h0);
        rd(3'd5, v); check("R1 level", v, 16'h0);

        // R11 field layout and readback
        wr(3'd0, 16'hA5C3); rd(3'd0, v); check("R11 trig_hi", v, 16'hA5C3);
        wr(3'd1, 16'hFFFF); rd(3'd1, v); check("R11 trig_lo bits1:0", v, 16'hFFFC);
        wr(3'd0, 16'h0); wr(3'd1, 16'h0);
        tick(4); wr(3'd3, 16'hFFFE);
        rd(3'd2, v); check("R11 sense clean", v, 16'h0);

        // R2 level high latency
        raw[3] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        rd(3'd2, v); check("R2 not yet", v & 16'h0008, 16'h0);
        @(posedge clk); @(negedge clk);
        rd(3'd2, v); check("R2 set", v & 16'h0008, 16'h0008);
        wr(3'd3, 16'h0008);
        rd(3'd2, v); check("R2 reasserts", v & 16'h0008, 16'h0008);
        raw[3] = 1'b0; tick(4);
        rd(3'd2, v); check("R2 held after drop", v & 16'h0008, 16'h0008);
        wr(3'd3, 16'h0008);
        rd(3'd2, v); check("R2 cleared", v & 16'h0008, 16'h0);

        // R6 write-one-to-clear
        raw[7] = 1'b1; tick(5); raw[7] = 1'b0; tick(5);
        wr(3'd3, 16'hFF7E);
        rd(3'd2, v); check("R6 zeros ignored", v, 16'h0080);
        wr(3'd3, 16'h0080);
        rd(3'd2, v); check("R6 one clears", v, 16'h0);

        // R3 active low level on source 2
        wr(3'd1, 16'h0010); tick(2);
        rd(3'd2, v); check("R3 low active", v & 16'h0004, 16'h0004);
        raw[2] = 1'b1; tick(5); wr(3'd3, 16'h0004);
        rd(3'd2, v); check("R3 high inactive", v & 16'h0004, 16'h0);
        wr(3'd1, 16'h0); raw[2] = 1'b0; tick(5); wr(3'd3, 16'hFFFE);

        // R4 rising edge on source 10
        wr(3'd0, 16'h0020);
        raw[10] = 1'b1; tick(5);
        rd(3'd2, v); check("R4 rise sets", v & 16'h0400, 16'h0400);
        wr(3'd3, 16'h0400); tick(3);
        rd(3'd2, v); check("R4 held high no reset", v & 16'h0400, 16'h0);
        raw[10] = 1'b0; tick(5);
        rd(3'd2, v); check("R4 fall ignored", v & 16'h0400, 16'h0);
        wr(3'd0, 16'h0);

        // R5 falling edge on source 5
        raw[5] = 1'b1; tick(5);
        wr(3'd1, 16'h0C00); wr(3'd3, 16'hFFFE); tick(3);
        rd(3'd2, v); check("R5 high no set", v & 16'h0020, 16'h0);
        raw[5] = 1'b0; tick(5);
        rd(3'd2, v); check("R5 fall sets", v & 16'h0020, 16'h0020);
        wr(3'd1, 16'h0); tick(2); wr(3'd3, 16'hFFFE);

        // R7 mask
        raw[6] = 1'b1; tick(6);
        check("R7 masked irl", {12'h0, irl_out}, 16'h0);
        rd(3'd2, v); check("R7 pending while masked", v & 16'h0040, 16'h0040);
        wr(3'd4, 16'hFFBE);
        check("R7 before edge", {12'h0, irl_out}, 16'h0);
        tick(1);
        check("R7 unmasked irl", {12'h0, irl_out}, 16'h6);

        // R9 keep and raise
        raw[4] = 1'b1; wr(3'd4, 16'hFFAE); tick(6);
        check("R9 keep", {12'h0, irl_out}, 16'h6);
        raw[12] = 1'b1; wr(3'd4, 16'hEFAE); tick(6);
        check("R9 raise", {12'h0, irl_out}, 16'hC);

        // R10 level clear
        wr(3'd5, 16'h000F);
        check("R10 no bit4", {12'h0, irl_out}, 16'hC);
        wr(3'd5, 16'h0010);
        check("R10 release", {12'h0, irl_out}, 16'h0);
        tick(1);
        check("R10 relatch", {12'h0, irl_out}, 16'hC);
        raw[12] = 1'b0; tick(5);
        wr(3'd3, 16'h1000); wr(3'd5, 16'h0010); tick(1);
        check("R10 next best", {12'h0, irl_out}, 16'h6);
        rd(3'd5, v); check("R10 level read", v, 16'h0006);

        // R8 priority table
        for (int i = 0; i < 8; i++) begin
            raw = '0; tick(5);
            wr(3'd3, 16'hFFFE);
            wr(3'd4, VEC[i][31:16]);
            raw = VEC[i][47:32]; tick(6);
            wr(3'd5, 16'h0010); tick(3);
            check($sformatf("R8 row %0d irl", i), {12'h0, irl_out}, VEC[i][15:0]);
            rd(3'd5, v);
            check($sformatf("R8 row %0d reg", i), v, VEC[i][15:0]);
        end

        finish_run();
    end
endmodule